// File: doc/BRIEF.md
# Serial channel register and status controller

This block is the byte-wide register front end of an asynchronous serial channel. A host reaches eight byte registers through a plain read/write strobe pair and a 3-bit offset. It holds the mode, bit-rate, control and two auxiliary configuration bytes. It keeps the transmit and receive flags, and drives four interrupt lines: receive, transmit, transmit-end and error.

Bytes to send go to an external serialiser as a one-cycle valid pulse with the data alongside. Received bytes and line-break events arrive from an external deserialiser as one-cycle pulses. A separate frame timer reports the end of each transmitted frame with a one-cycle pulse.

The block does not shift bits, generate parity, run smart-card mode or decode multiprocessor addresses. The configuration bits for those functions are only stored and read back.

Top module: `uart_csr`

## Requirements
- R1: After reset the registers read as follows: offset 0 (mode) 0x00, offset 1 (bit rate) 0xFF, offset 2 (control) 0x00, offset 3 (transmit data) 0xFF, offset 4 (status) 0x84, offset 5 (receive data) 0x00, offset 6 0x00 and offset 7 0x00. All interrupt outputs and the transmit valid output are low after reset.
- R2: Writes to offset 0 and offset 1 take effect only while control bit 5 (transmit enable) and control bit 4 (receive enable) are both 0. Otherwise those writes are ignored.
- R3: Any control write with bit 5 set sets status bit 7 (transmit empty) and status bit 2 (transmit end) to 1. If bit 7 of the written control value (transmit interrupt enable) is 1, the write also gives a one-clock pulse on `irq_tx_o`.
- R4: A write to offset 3 while transmit end is 1 starts a frame. In the next cycle `tx_valid_o` pulses with `tx_data_o` equal to the byte. Transmit empty becomes 1, transmit end becomes 0 and `irq_tend_o` goes low. `irq_tx_o` pulses if transmit interrupts are enabled.
- R5: A write to offset 3 while transmit end is 0 only holds the byte. Transmit empty becomes 0 and no frame starts.
- R6: On `frame_done_i`, if transmit empty is 0, the held byte is started as in R4. If transmit empty is 1, transmit end becomes 1, and `irq_tend_o` rises if control bit 2 (transmit-end interrupt enable) is 1.
- R7: A received byte that arrives while status bit 6 (receive full) is 0 is stored in offset 5 and sets receive full. If control bit 6 (receive interrupt enable) is 1, `irq_rx_o` pulses for one clock.
- R8: A received byte that arrives while receive full is 1 is discarded, and the stored byte is kept. Status bit 5 (overrun) is set, and `irq_err_o` rises if receive interrupts are enabled.
- R9: Reading offset 5 clears receive full. A line break sets status bit 4 (framing error) and raises `irq_err_o` if receive interrupts are enabled.
- R10: A status write stores bit 0 and bits 5:3 of the written value. `irq_err_o` drops only in two cases. The first is a status write that leaves bits 5:3 zero after the most recent status read saw one of them set. The second is a control write with bit 6 clear.
- R11: A control write with bit 2 clear drops `irq_tend_o`.
- R12: `irq_rx_o` and `irq_tx_o` are single-clock pulses. Offsets 6 and 7 and status bit 0 read back what was written. Status bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (the read side effects happen at the clock edge) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tx_valid_o | output | 1 | One-cycle pulse that starts a frame |
| tx_data_o | output | 8 | Byte to serialise |
| rx_valid_i | input | 1 | Received byte is valid |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Line break detected |
| frame_done_i | input | 1 | The frame timer reports the end of the current frame |
| irq_rx_o | output | 1 | Receive interrupt pulse |
| irq_tx_o | output | 1 | Transmit interrupt pulse |
| irq_tend_o | output | 1 | Transmit-end interrupt level |
| irq_err_o | output | 1 | Error interrupt level |

## Verification
The bench builds the block with its default reset values for bit rate and transmit data (both 0xFF), so the R1 readback can compare against fixed constants. It drives one complete transmit sequence: an immediate start, a held byte, and the frame end that releases the held byte and then the idle frame end. Every started frame is checked against a queue of expected bytes. The receive side is driven into overrun and line-break errors, so that both ways of dropping the error interrupt are reached, along with the case where a status write without a prior status read must not drop it.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] OFS_MODE = 3'd0;
  localparam logic [AW-1:0] OFS_RATE = 3'd1;
  localparam logic [AW-1:0] OFS_CTRL = 3'd2;
  localparam logic [AW-1:0] OFS_TXD  = 3'd3;
  localparam logic [AW-1:0] OFS_STAT = 3'd4;
  localparam logic [AW-1:0] OFS_RXD  = 3'd5;
  localparam logic [AW-1:0] OFS_AUXA = 3'd6;
  localparam logic [AW-1:0] OFS_AUXB = 3'd7;

  // control bit positions
  localparam int CB_TEIE = 2;
  localparam int CB_RE   = 4;
  localparam int CB_TE   = 5;
  localparam int CB_RIE  = 6;
  localparam int CB_TIE  = 7;
endpackage

// File: rtl/uart_csr_cfg.sv
module uart_csr_cfg
  import uart_csr_pkg::*;
#(
  parameter logic [DW-1:0] RST_RATE = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] rate_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] auxa_o,
  output logic [DW-1:0] auxb_o
);
  logic locked;
  assign locked = ctrl_o[CB_TE] | ctrl_o[CB_RE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      rate_o <= RST_RATE;
      ctrl_o <= '0;
      auxa_o <= '0;
      auxb_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_MODE: if (!locked) mode_o <= wdata_i;
        OFS_RATE: if (!locked) rate_o <= wdata_i;
        OFS_CTRL: ctrl_o <= wdata_i;
        OFS_AUXA: auxa_o <= wdata_i;
        OFS_AUXB: auxb_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_csr_tx.sv
module uart_csr_tx
  import uart_csr_pkg::*;
#(
  parameter logic [DW-1:0] RST_TXD = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          te_set_i,     // control write with transmit enable
  input  logic          teie_clr_i,   // control write with transmit-end irq enable clear
  input  logic          tie_i,        // effective transmit irq enable
  input  logic          teie_i,       // effective transmit-end irq enable
  input  logic          txd_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          frame_done_i,
  output logic [DW-1:0] tdr_o,
  output logic          tdre_o,
  output logic          tend_o,
  output logic          tx_valid_o,
  output logic          irq_tx_o,
  output logic          irq_tend_o
);
  logic [DW-1:0] tdr_n;
  logic tdre_n, tend_n, irq_tend_n, start, txi;

  always_comb begin
    tdr_n      = tdr_o;
    tdre_n     = tdre_o;
    tend_n     = tend_o;
    irq_tend_n = irq_tend_o;
    start      = 1'b0;
    txi        = 1'b0;
    if (te_set_i) begin
      tdre_n = 1'b1;
      tend_n = 1'b1;
      txi    = tie_i;
    end
    if (teie_clr_i) irq_tend_n = 1'b0;
    if (txd_wr_i) begin
      tdr_n = wdata_i;
      if (tend_n) start  = 1'b1;
      else        tdre_n = 1'b0;
    end
    if (frame_done_i && !start) begin
      if (!tdre_n) start = 1'b1;
      else begin
        tend_n = 1'b1;
        if (teie_i) irq_tend_n = 1'b1;
      end
    end
    if (start) begin
      tdre_n     = 1'b1;
      tend_n     = 1'b0;
      irq_tend_n = 1'b0;
      txi        = tie_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_o      <= RST_TXD;
      tdre_o     <= 1'b1;
      tend_o     <= 1'b1;
      tx_valid_o <= 1'b0;
      irq_tx_o   <= 1'b0;
      irq_tend_o <= 1'b0;
    end else begin
      tdr_o      <= tdr_n;
      tdre_o     <= tdre_n;
      tend_o     <= tend_n;
      tx_valid_o <= start;
      irq_tx_o   <= txi;
      irq_tend_o <= irq_tend_n;
    end
  end
endmodule

// File: rtl/uart_csr_rx.sv
module uart_csr_rx
  import uart_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rie_i,        // effective receive irq enable
  input  logic          rie_clr_i,    // control write with receive irq enable clear
  input  logic          stat_wr_i,
  input  logic          stat_rd_i,
  input  logic          rxd_rd_i,
  input  logic [2:0]    err_wr_i,     // {overrun, framing, parity} written
  input  logic          mpbt_wr_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_break_i,
  output logic [DW-1:0] rdr_o,
  output logic          rdrf_o,
  output logic [2:0]    err_o,
  output logic          mpbt_o,
  output logic          irq_rx_o,
  output logic          irq_err_o
);
  logic [DW-1:0] rdr_n;
  logic [2:0] err_n, snap_q, snap_n;
  logic rdrf_n, mpbt_n, irq_err_n, rxi;

  always_comb begin
    rdr_n     = rdr_o;
    rdrf_n    = rdrf_o;
    err_n     = err_o;
    mpbt_n    = mpbt_o;
    snap_n    = snap_q;
    irq_err_n = irq_err_o;
    rxi       = 1'b0;
    if (rxd_rd_i)  rdrf_n = 1'b0;
    if (stat_rd_i) snap_n = err_o;
    if (stat_wr_i) begin
      mpbt_n = mpbt_wr_i;
      err_n  = err_wr_i;
      if (snap_q != 3'b000 && err_wr_i == 3'b000) irq_err_n = 1'b0;
    end
    if (rie_clr_i) irq_err_n = 1'b0;
    if (rx_valid_i) begin
      if (rdrf_o) begin
        err_n[2] = 1'b1;
        if (rie_i) irq_err_n = 1'b1;
      end else begin
        rdr_n  = rx_data_i;
        rdrf_n = 1'b1;
        rxi    = rie_i;
      end
    end
    if (rx_break_i) begin
      err_n[1] = 1'b1;
      if (rie_i) irq_err_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_o     <= '0;
      rdrf_o    <= 1'b0;
      err_o     <= '0;
      mpbt_o    <= 1'b0;
      snap_q    <= '0;
      irq_rx_o  <= 1'b0;
      irq_err_o <= 1'b0;
    end else begin
      rdr_o     <= rdr_n;
      rdrf_o    <= rdrf_n;
      err_o     <= err_n;
      mpbt_o    <= mpbt_n;
      snap_q    <= snap_n;
      irq_rx_o  <= rxi;
      irq_err_o <= irq_err_n;
    end
  end
endmodule

// File: rtl/uart_csr.sv
module uart_csr
  import uart_csr_pkg::*;
#(
  parameter logic [7:0] RST_RATE = 8'hFF,
  parameter logic [7:0] RST_TXD  = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_break_i,
  input  logic       frame_done_i,
  output logic       irq_rx_o,
  output logic       irq_tx_o,
  output logic       irq_tend_o,
  output logic       irq_err_o
);
  logic [DW-1:0] mode_q, rate_q, ctrl_q, auxa_q, auxb_q, tdr_q, rdr_q, stat;
  logic [2:0] err_q;
  logic tdre_q, tend_q, rdrf_q, mpbt_q;
  logic ctrl_wr, tie_eff, teie_eff, rie_eff;

  assign ctrl_wr  = wr_i && addr_i == OFS_CTRL;
  assign tie_eff  = ctrl_wr ? wdata_i[CB_TIE]  : ctrl_q[CB_TIE];
  assign teie_eff = ctrl_wr ? wdata_i[CB_TEIE] : ctrl_q[CB_TEIE];
  assign rie_eff  = ctrl_wr ? wdata_i[CB_RIE]  : ctrl_q[CB_RIE];

  uart_csr_cfg #(.RST_RATE(RST_RATE)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .mode_o(mode_q), .rate_o(rate_q), .ctrl_o(ctrl_q),
    .auxa_o(auxa_q), .auxb_o(auxb_q)
  );

  uart_csr_tx #(.RST_TXD(RST_TXD)) u_tx (
    .clk_i, .rst_ni,
    .te_set_i    (ctrl_wr && wdata_i[CB_TE]),
    .teie_clr_i  (ctrl_wr && !wdata_i[CB_TEIE]),
    .tie_i       (tie_eff),
    .teie_i      (teie_eff),
    .txd_wr_i    (wr_i && addr_i == OFS_TXD),
    .wdata_i,
    .frame_done_i,
    .tdr_o(tdr_q), .tdre_o(tdre_q), .tend_o(tend_q),
    .tx_valid_o, .irq_tx_o, .irq_tend_o
  );

  uart_csr_rx u_rx (
    .clk_i, .rst_ni,
    .rie_i      (rie_eff),
    .rie_clr_i  (ctrl_wr && !wdata_i[CB_RIE]),
    .stat_wr_i  (wr_i && addr_i == OFS_STAT),
    .stat_rd_i  (rd_i && addr_i == OFS_STAT),
    .rxd_rd_i   (rd_i && addr_i == OFS_RXD),
    .err_wr_i   (wdata_i[5:3]),
    .mpbt_wr_i  (wdata_i[0]),
    .rx_valid_i, .rx_data_i, .rx_break_i,
    .rdr_o(rdr_q), .rdrf_o(rdrf_q), .err_o(err_q), .mpbt_o(mpbt_q),
    .irq_rx_o, .irq_err_o
  );

  assign stat      = {tdre_q, rdrf_q, err_q, tend_q, 1'b0, mpbt_q};
  assign tx_data_o = tdr_q;

  always_comb begin
    case (addr_i)
      OFS_MODE: rdata_o = mode_q;
      OFS_RATE: rdata_o = rate_q;
      OFS_CTRL: rdata_o = ctrl_q;
      OFS_TXD:  rdata_o = tdr_q;
      OFS_STAT: rdata_o = stat;
      OFS_RXD:  rdata_o = rdr_q;
      OFS_AUXA: rdata_o = auxa_q;
      default:  rdata_o = auxb_q;
    endcase
  end
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       frame_done_i,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       irq_rx_o,
  input logic       irq_tend_o,
  input logic [7:0] mode_q,
  input logic [7:0] ctrl_q,
  input logic [7:0] stat,
  input logic [7:0] rdr_q
);
  assert_mode_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 3'd0 && (ctrl_q[5] || ctrl_q[4]) |=> $stable(mode_q));

  assert_tx_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 3'd3 && stat[2]
    |=> tx_valid_o && tx_data_o == $past(wdata_i) && !irq_tend_o && stat[7] && !stat[2]);

  assert_tx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 3'd3 && !stat[2] && !frame_done_i |=> !stat[7] && !tx_valid_o);

  assert_idle_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i && stat[7] && !(wr_i && addr_i == 3'd3) |=> stat[2]);

  assert_rx_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !stat[6] |=> stat[6] && rdr_q == $past(rx_data_i));

  assert_rx_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && stat[6] |=> stat[5] && $stable(rdr_q));

  assert_rx_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |=> !irq_rx_o);

  assert_rd_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 3'd5 && !rx_valid_i |=> !stat[6]);
endmodule

bind uart_csr uart_csr_chk i_chk (
  .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
  .rx_valid_i, .rx_data_i, .frame_done_i,
  .tx_valid_o, .tx_data_o, .irq_rx_o, .irq_tend_o,
  .mode_q, .ctrl_q, .stat, .rdr_q
);

// File: tb/test_uart_csr.sv
module test_uart_csr;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_i = 0, rd_i = 0, rx_valid_i = 0, rx_break_i = 0, frame_done_i = 0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rx_data_i = '0;
  logic [7:0] rdata_o, tx_data_o;
  logic tx_valid_o, irq_rx_o, irq_tx_o, irq_tend_o, irq_err_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_tx[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_csr i_uart_csr (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // scoreboard monitor for frames handed to the serialiser
  always @(negedge clk_i) if (rst_ni && tx_valid_o) begin
    n_cmp++;
    if (exp_tx.size() == 0) begin
      n_bad++;
      $display("FAIL R4/R6: unexpected frame %02h expected none", tx_data_o);
    end else begin
      logic [7:0] e;
      e = exp_tx.pop_front();
      if (tx_data_o !== e) begin
        n_bad++;
        $display("FAIL R4/R6: frame %02h expected %02h", tx_data_o, e);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_i = 1; addr_i = a; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    check(req, d, e);
  endtask

  task automatic rx(logic [7:0] d);
    @(negedge clk_i); rx_valid_i = 1; rx_data_i = d;
    @(negedge clk_i); rx_valid_i = 0;
  endtask

  task automatic brk();
    @(negedge clk_i); rx_break_i = 1;
    @(negedge clk_i); rx_break_i = 0;
  endtask

  task automatic fdone();
    @(negedge clk_i); frame_done_i = 1;
    @(negedge clk_i); frame_done_i = 0;
  endtask

  task automatic finish_run();
    if (exp_tx.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R4/R6: %0d frames missing expected 0", exp_tx.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd_chk("R1 mode", 3'd0, 8'h00);
    rd_chk("R1 rate", 3'd1, 8'hFF);
    rd_chk("R1 ctrl", 3'd2, 8'h00);
    rd_chk("R1 txd",  3'd3, 8'hFF);
    rd_chk("R1 stat", 3'd4, 8'h84);
    rd_chk("R1 rxd",  3'd5, 8'h00);
    rd_chk("R1 auxa", 3'd6, 8'h00);
    rd_chk("R1 auxb", 3'd7, 8'h00);
    check("R1 irqs", {3'b0, tx_valid_o, irq_rx_o, irq_tx_o, irq_tend_o, irq_err_o}, 8'h00);

    // R2 unlocked writes, R12 aux storage
    wr(3'd0, 8'h5A); wr(3'd1, 8'h33);
    rd_chk("R2 mode unlocked", 3'd0, 8'h5A);
    rd_chk("R2 rate unlocked", 3'd1, 8'h33);
    wr(3'd6, 8'hA5); wr(3'd7, 8'h11);
    rd_chk("R12 auxa", 3'd6, 8'hA5);
    rd_chk("R12 auxb", 3'd7, 8'h11);

    // R3 enable transmit with TIE and TEIE
    wr(3'd2, 8'hA4);
    check("R3 irq_tx pulse", {7'b0, irq_tx_o}, 8'h01);
    @(negedge clk_i);
    check("R12 irq_tx single", {7'b0, irq_tx_o}, 8'h00);
    rd_chk("R3 stat", 3'd4, 8'h84);

    // R2 locked
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    rd_chk("R2 mode locked", 3'd0, 8'h5A);
    rd_chk("R2 rate locked", 3'd1, 8'h33);

    // R4 immediate start
    exp_tx.push_back(8'h3C);
    wr(3'd3, 8'h3C);
    check("R4 irq_tx pulse", {7'b0, irq_tx_o}, 8'h01);
    rd_chk("R4 stat", 3'd4, 8'h80);

    // R5 held byte
    wr(3'd3, 8'hC3);
    check("R5 no irq_tx", {7'b0, irq_tx_o}, 8'h00);
    rd_chk("R5 stat", 3'd4, 8'h00);

    // R6 frame done sends held byte
    exp_tx.push_back(8'hC3);
    fdone();
    check("R6 irq_tx on held start", {7'b0, irq_tx_o}, 8'h01);
    rd_chk("R6 stat busy", 3'd4, 8'h80);

    // R6 idle frame done raises transmit end
    fdone();
    check("R6 irq_tend", {7'b0, irq_tend_o}, 8'h01);
    rd_chk("R6 stat idle", 3'd4, 8'h84);

    // R11 clear TEIE
    wr(3'd2, 8'hA0);
    check("R11 irq_tend low", {7'b0, irq_tend_o}, 8'h00);

    // R7 receive with RIE
    wr(3'd2, 8'h70);
    rx(8'h11);
    check("R7 irq_rx pulse", {7'b0, irq_rx_o}, 8'h01);
    @(negedge clk_i);
    check("R12 irq_rx single", {7'b0, irq_rx_o}, 8'h00);

    // R8 overrun
    rx(8'h22);
    check("R8 irq_err", {7'b0, irq_err_o}, 8'h01);
    // R10 status write without prior read that saw error: irq stays
    wr(3'd4, 8'h00);
    check("R10 irq_err kept", {7'b0, irq_err_o}, 8'h01);
    rd_chk("R8 stat", 3'd4, 8'hC4);
    rd_chk("R8 data kept", 3'd5, 8'h11);
    rd_chk("R9 rdrf cleared", 3'd4, 8'h84);

    // R9 break, R10 read-then-write clear
    brk();
    rd_chk("R9 framing flag", 3'd4, 8'h94);
    wr(3'd4, 8'h00);
    check("R10 irq_err cleared", {7'b0, irq_err_o}, 8'h00);
    rd_chk("R10 stat", 3'd4, 8'h84);

    // R9 break irq, R10 clear by RIE
    brk();
    check("R9 irq_err", {7'b0, irq_err_o}, 8'h01);
    wr(3'd2, 8'h30);
    check("R10 irq_err by rie", {7'b0, irq_err_o}, 8'h00);

    // R7 receive without RIE
    rx(8'h55);
    check("R7 no irq_rx", {7'b0, irq_rx_o}, 8'h00);
    rd_chk("R7 data", 3'd5, 8'h55);

    // R12 multiprocessor transmit bit storage
    wr(3'd4, 8'h01);
    rd_chk("R12 stat bit0", 3'd4, 8'h85);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule